// File: doc/BRIEF.md
# Frame Controller Register File with Frame-End Interrupt

This block is the host-visible register file of a framebuffer controller. The host reaches it through a simple byte-wide read/write port with a 5-bit byte offset. The upper half of the offset space, 0x10 to 0x1F, holds the registers. 0x10 is the control byte. 0x11 is the status byte. 0x12 to 0x1F are general-purpose bytes that hold values such as cursor limits and video control settings. The lower half of the offset space holds no storage.

The display timing logic pulses `frame_end` once per frame. When the interrupt enable bit of the control byte is set, that pulse sets a pending flag. The pending flag drives a level-sensitive interrupt line. The host acknowledges the interrupt by writing anything to the status offset. A status read combines fixed identity bits (monitor code and colour board) with the live pending flag. Read data is returned one cycle after the read request, together with a valid strobe.

Top module: `frame_ctl_regs`

## Requirements
- R1: After reset, `irq` is 0, every byte at 0x10 and 0x12 to 0x1F reads 0x00, and status (0x11) reads 0x61.
- R2: Offset 0x10 is a full 8-bit read/write control byte; bit 7 of it is the interrupt enable.
- R3: Offsets 0x12 to 0x1F are independent 8-bit read/write bytes. Each is indexed by offset minus 0x10.
- R4: A read of 0x11 returns 0x61 with bit 7 equal to the pending flag, so it reads 0x61 when idle and 0xE1 when pending.
- R5: A `frame_end` pulse while control bit 7 is 1 sets the pending flag. `irq` is high from the next clock edge.
- R6: A `frame_end` pulse while control bit 7 is 0 changes neither `irq` nor the status read value.
- R7: Any write to 0x11 clears the pending flag and lowers `irq` at the next edge, whatever the data. The written data never shows in the status read.
- R8: Reads of offsets 0x00 to 0x0F return 0x00. Writes to them change no register.
- R9: When a `frame_end` pulse with enable set and a status write fall in the same cycle, the pending flag ends set.
- R10: Each read request yields exactly one `host_rvalid` pulse with its data on the next cycle. `host_rvalid` is low otherwise.
- R11: Once set, the pending flag stays set until a status write, even if the enable bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write request for this cycle |
| host_rd | input | 1 | Read request for this cycle |
| host_addr | input | 5 | Byte offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data strobe, one cycle after host_rd |
| frame_end | input | 1 | One-cycle end-of-frame pulse from timing logic |
| irq | output | 1 | Level interrupt, high while pending |

## Verification
The bench drives a frame-end pulse and a status acknowledge in the same cycle, both with the flag already pending and with it clear. A design that let the acknowledge win would drop an interrupt there. It clears the enable while an interrupt is pending, to catch a design that ties `irq` to the enable instead of holding the flag. It writes nonzero data to offsets in the lower half and to the status byte. A design that aliased the lower half onto the bank, or stored status data, would read back wrong values. It walks distinct patterns through all fourteen general bytes, which exposes decode slips that would merge or drop entries.

// File: rtl/frc_pkg.sv
package frc_pkg;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int BANK_DEPTH = 16;
    localparam int IDX_W      = $clog2(BANK_DEPTH);
    localparam int CTRL_IDX   = 0;
    localparam int STAT_IDX   = 1;
    localparam int IE_BIT     = 7;
    localparam int PEND_BIT   = 7;
    localparam logic [DATA_W-1:0] ID_BITS = 8'h61;

    typedef enum logic [1:0] {
        ACC_LOW  = 2'd0,
        ACC_STAT = 2'd1,
        ACC_BANK = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [IDX_W-1:0] idx;
        logic             wr;
        logic             rd;
    } frc_req_t;

    function automatic acc_kind_e classify(input logic [ADDR_W-1:0] a);
        if (!a[ADDR_W-1])
            return ACC_LOW;
        else if (a[IDX_W-1:0] == IDX_W'(STAT_IDX))
            return ACC_STAT;
        else
            return ACC_BANK;
    endfunction
endpackage

// File: rtl/frc_decode.sv
module frc_decode
    import frc_pkg::*;
(
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output frc_req_t          req
);
    always_comb begin
        req.kind = classify(addr);
        req.idx  = addr[IDX_W-1:0];
        req.wr   = wr_en;
        req.rd   = rd_en;
    end
endmodule

// File: rtl/frc_bank.sv
module frc_bank
    import frc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  frc_req_t          req,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_byte,
    output logic              ie
);
    logic [DATA_W-1:0] ent [BANK_DEPTH];

    for (genvar g = 0; g < BANK_DEPTH; g++) begin : g_ent
        if (g == STAT_IDX) begin : g_hole
            // status lives in the interrupt unit; no storage here
            assign ent[g] = '0;
        end else begin : g_byte
            always_ff @(posedge clk) begin
                if (rst)
                    ent[g] <= '0;
                else if (req.wr && req.kind == ACC_BANK && req.idx == IDX_W'(g))
                    ent[g] <= wdata;
            end
        end
    end

    assign rd_byte = ent[req.idx];
    assign ie      = ent[CTRL_IDX][IE_BIT];
endmodule

// File: rtl/frc_irq.sv
module frc_irq (
    input  logic clk,
    input  logic rst,
    input  logic frame_end,
    input  logic ie,
    input  logic ack,
    output logic pend
);
    logic set_now;
    assign set_now = frame_end && ie;

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (set_now)
            pend <= 1'b1;
        else if (ack)
            pend <= 1'b0;
    end
endmodule

// File: rtl/frame_ctl_regs.sv
module frame_ctl_regs
    import frc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              frame_end,
    output logic              irq
);
    frc_req_t          req;
    logic [DATA_W-1:0] bank_byte;
    logic [DATA_W-1:0] stat_byte;
    logic [DATA_W-1:0] rd_mux;
    logic              ctrl_ie;
    logic              pend;
    logic              ack;

    frc_decode u_dec (
        .wr_en (host_wr),
        .rd_en (host_rd),
        .addr  (host_addr),
        .req   (req)
    );

    frc_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wdata   (host_wdata),
        .rd_byte (bank_byte),
        .ie      (ctrl_ie)
    );

    assign ack = req.wr && req.kind == ACC_STAT;

    frc_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .ie        (ctrl_ie),
        .ack       (ack),
        .pend      (pend)
    );

    always_comb begin
        stat_byte           = ID_BITS;
        stat_byte[PEND_BIT] = pend;
        unique case (req.kind)
            ACC_STAT: rd_mux = stat_byte;
            ACC_BANK: rd_mux = bank_byte;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= req.rd;
            if (req.rd)
                host_rdata <= rd_mux;
        end
    end

    assign irq = pend;
endmodule

// File: rtl/frc_chk.sv
module frc_chk
    import frc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_rvalid,
    input logic              frame_end,
    input logic              ie,
    input logic              irq
);
    logic stat_wr;
    assign stat_wr = host_wr && host_addr == ADDR_W'(5'h11);

    // R1
    reset_low_chk: assert property (@(posedge clk) rst |=> !irq);
    // R5
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && ie) |=> irq);
    // R6
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq && !(frame_end && ie)) |=> !irq);
    // R7
    ack_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !(frame_end && ie)) |=> !irq);
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !stat_wr) |=> irq);
    // R10
    rvalid_chk: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> host_rvalid);
    // R10
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> !host_rvalid);
    // R8
    low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_addr[ADDR_W-1]) |=> host_rdata == '0);
    // R4
    stat_id_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == ADDR_W'(5'h11)) |=> host_rdata[6:0] == 7'h61);
endmodule

bind frame_ctl_regs frc_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .frame_end   (frame_end),
    .ie          (ctrl_ie),
    .irq         (irq)
);

// File: tb/test_frame_ctl_regs.sv
module test_frame_ctl_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_rvalid;
    logic       frame_end = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #5 clk = ~clk;

    frame_ctl_regs i_frame_ctl_regs (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .frame_end(frame_end), .irq(irq)
    );

    task automatic cyc(input bit wr, input bit rd, input logic [4:0] a,
                       input logic [7:0] d, input bit fe);
        @(negedge clk);
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d; frame_end = fe;
    endtask

    task automatic wr_b(input logic [4:0] a, input logic [7:0] d);
        cyc(1'b1, 1'b0, a, d, 1'b0);
    endtask

    task automatic rd_b(input logic [4:0] a, input logic [7:0] exp, input string tag);
        cyc(1'b0, 1'b1, a, 8'h00, 1'b0);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        cyc(1'b0, 1'b0, 5'h00, 8'h00, 1'b0);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b", tag, irq, exp);
        end
    endtask

    // monitor: pops one expected item per returned read
    always @(negedge clk) begin
        if (!rst && host_rvalid) begin
            checks++;
            if (q_exp.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected rvalid actual 1 expected 0");
            end else begin
                logic [7:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (host_rdata !== e) begin
                    errors++;
                    $display("FAIL %s rdata actual %02h expected %02h", t, host_rdata, e);
                end
            end
        end
    end

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual timeout expected completion");
            end
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                // R1 reset state
                chk_irq(1'b0, "R1");
                rd_b(5'h10, 8'h00, "R1");
                rd_b(5'h1F, 8'h00, "R1");
                rd_b(5'h11, 8'h61, "R1");
                // R2 control byte
                wr_b(5'h10, 8'h5A);
                rd_b(5'h10, 8'h5A, "R2");
                // R3 general bytes, distinct patterns
                for (int i = 2; i < 16; i++) wr_b(5'(16 + i), 8'(i * 17) ^ 8'hA5);
                for (int i = 2; i < 16; i++) rd_b(5'(16 + i), 8'(i * 17) ^ 8'hA5, "R3");
                // R8 lower half ignored and reads zero
                wr_b(5'h05, 8'hFF);
                wr_b(5'h02, 8'h77);
                wr_b(5'h00, 8'h3C);
                rd_b(5'h05, 8'h00, "R8");
                rd_b(5'h00, 8'h00, "R8");
                rd_b(5'h12, 8'(2 * 17) ^ 8'hA5, "R8");
                rd_b(5'h10, 8'h5A, "R8");
                // R6 frame end with enable clear
                cyc(1'b0, 1'b0, 5'h00, 8'h00, 1'b1);
                chk_irq(1'b0, "R6");
                rd_b(5'h11, 8'h61, "R6");
                // R5 enable and frame end
                wr_b(5'h10, 8'h80);
                cyc(1'b0, 1'b0, 5'h00, 8'h00, 1'b1);
                chk_irq(1'b1, "R5");
                rd_b(5'h11, 8'hE1, "R4");
                // R11 pending held after enable cleared
                wr_b(5'h10, 8'h00);
                cyc(1'b0, 1'b0, 5'h00, 8'h00, 1'b1);
                chk_irq(1'b1, "R11");
                // R7 acknowledge with zero data
                wr_b(5'h11, 8'h00);
                chk_irq(1'b0, "R7");
                rd_b(5'h11, 8'h61, "R7");
                wr_b(5'h11, 8'hFF);
                rd_b(5'h11, 8'h61, "R7");
                rd_b(5'h10, 8'h00, "R7");
                // R9 same-cycle set and acknowledge
                wr_b(5'h10, 8'h80);
                cyc(1'b1, 1'b0, 5'h11, 8'h00, 1'b1);
                chk_irq(1'b1, "R9");
                cyc(1'b1, 1'b0, 5'h11, 8'h80, 1'b1);
                chk_irq(1'b1, "R9");
                wr_b(5'h11, 8'h80);
                chk_irq(1'b0, "R7");
                repeat (3) cyc(1'b0, 1'b0, 5'h00, 8'h00, 1'b0);
                checks++;
                if (q_exp.size() != 0) begin
                    errors++;
                    $display("FAIL R10 pending reads actual %0d expected 0", q_exp.size());
                end
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule